// File: doc/BRIEF.md
# Serial Counter-Word Loader with Enhancement Register

This block takes a three-wire serial stream (a serial clock, a data line and an active-low load strobe) and turns it into a parallel counter word for a frequency synthesizer. All three serial wires, plus a hop strobe and an enhancement-write select, are brought into the system clock domain through two-flop synchronisers. Their edges are then detected in that domain. Each rising edge of the serial clock shifts one data bit into one of two shift registers. The enhancement-write select decides which one: a wide primary register or a narrow enhancement register.

The primary register is double-buffered. Shifting never disturbs the word the counters see. A rising edge on either the load strobe or the hop strobe copies the primary register in parallel into a holding register. That holding register drives the counter word. A direct-mode input bypasses the serial path and passes a parallel word through instead. The enhancement register only has an effect while the active-low enhancement-mode input is asserted. A single data-out pin is also live only in that mode.

Top module: `serial_cfg_loader`

## Requirements
- R1: Data enters MSB first: after W bits are shifted on rising serial-clock edges with the load strobe low and a load-strobe rise follows, the counter word equals those bits with the first bit at the highest position (W = 20 by default).
- R2: While the synchronised load strobe is high, serial-clock edges shift neither register.
- R3: With enhancement-write high, bits shift into the 8-bit enhancement register MSB first and the primary register is left untouched.
- R4: The holding register, and so the counter word in serial mode, changes only on a strobe rise. Shifting alone never changes it.
- R5: A rising edge on the hop strobe copies the primary register into the holding register, just as a load-strobe rise does.
- R6: With direct high the counter word equals the parallel input. With direct low it equals the holding register.
- R7: The enhancement output equals the enhancement register while enhancement-mode (active low) is 0, and is all zeros while it is 1.
- R8: The data-out pin carries the enhancement register's bit 7 while enhancement-mode is 0, and is 0 otherwise.
- R9: After reset the holding register, primary register and enhancement register are all zero.
- R10: A strobe that rises after fewer than W bits copies the primary register as-is: the old contents shifted left by the number of new bits, with the new bits in the low positions. No error indication is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock (asynchronous) |
| sdata | input | 1 | Serial data, MSB first |
| load_n | input | 1 | Load strobe: shifting allowed while low, transfer on rise |
| hop | input | 1 | Alternate transfer strobe, transfer on rise |
| enh_wr | input | 1 | 1 routes bits to the enhancement register, 0 to the primary |
| direct | input | 1 | 1 selects the parallel word as the counter word |
| enh_mode_n | input | 1 | Active-low enhancement enable |
| par_word | input | 20 | Parallel counter word for direct mode |
| cfg_word | output | 20 | Counter word to the synthesizer counters |
| enh_word | output | 8 | Effective enhancement bits |
| dout | output | 1 | Data-out, live only in enhancement mode |

## Verification
A corrupt primary register stays hidden until the next strobe rise. At that point it appears on the counter word about three system clocks after the strobe edge, so each check raises a strobe and waits for the synchroniser delay. A wrong routing or a missing gate on the shift enable shows up as a changed counter word after a later hop, or as a changed enhancement output. Walking-one words through every primary bit position expose ordering or bit-loss faults directly in the counter word. A partial shift followed by a hop checks the shift-left-and-insert arithmetic.

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader #(
  parameter int PRI_W = 20,
  parameter int ENH_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk,
  input  logic             sdata,
  input  logic             load_n,
  input  logic             hop,
  input  logic             enh_wr,
  input  logic             direct,
  input  logic             enh_mode_n,
  input  logic [PRI_W-1:0] par_word,
  output logic [PRI_W-1:0] cfg_word,
  output logic [ENH_W-1:0] enh_word,
  output logic             dout
);

  logic [2:0] sck_q, ld_q, hop_q;
  logic [1:0] dat_q, ew_q;
  logic [PRI_W-1:0] pri_sr, hold_q;
  logic [ENH_W-1:0] enh_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= '0;
      ld_q  <= '0;
      hop_q <= '0;
      dat_q <= '0;
      ew_q  <= '0;
    end else begin
      sck_q <= {sck_q[1:0], sclk};
      ld_q  <= {ld_q[1:0], load_n};
      hop_q <= {hop_q[1:0], hop};
      dat_q <= {dat_q[0], sdata};
      ew_q  <= {ew_q[0], enh_wr};
    end
  end

  wire sck_rise  = sck_q[1] & ~sck_q[2];
  wire shift_en  = sck_rise & ~ld_q[1];
  wire shift_pri = shift_en & ~ew_q[1];
  wire shift_enh = shift_en & ew_q[1];
  wire xfer      = (ld_q[1] & ~ld_q[2]) | (hop_q[1] & ~hop_q[2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_sr <= '0;
      enh_sr <= '0;
      hold_q <= '0;
    end else begin
      if (shift_pri) pri_sr <= {pri_sr[PRI_W-2:0], dat_q[1]};
      if (shift_enh) enh_sr <= {enh_sr[ENH_W-2:0], dat_q[1]};
      if (xfer)      hold_q <= pri_sr;
    end
  end

  assign cfg_word = direct ? par_word : hold_q;
  assign enh_word = enh_mode_n ? '0 : enh_sr;
  assign dout     = ~enh_mode_n & enh_sr[ENH_W-1];

  p_shift_msb_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    shift_pri |=> pri_sr == {$past(pri_sr[PRI_W-2:0]), $past(dat_q[1])});
  p_idle_when_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_q[1] |=> $stable(pri_sr) && $stable(enh_sr));
  p_enh_leaves_pri_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ew_q[1] |=> $stable(pri_sr));
  p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> $stable(hold_q));
  p_hold_copies_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> hold_q == $past(pri_sr));
  p_dout_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (enh_mode_n && $stable(enh_mode_n)) |-> !dout);

endmodule

// File: tb/serial_cfg_loader_tb.sv
module serial_cfg_loader_tb;
  localparam int CLK_P = 10;
  localparam int W = 20;
  localparam int E = 8;

  logic clk = 0, rst_n = 0;
  logic sclk = 0, sdata = 0, load_n = 0, hop = 0, enh_wr = 0, direct = 0, enh_mode_n = 1;
  logic [W-1:0] par_word = '0;
  logic [W-1:0] cfg_word;
  logic [E-1:0] enh_word;
  logic dout;
  int compared = 0, mismatched = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  serial_cfg_loader u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata(sdata), .load_n(load_n),
    .hop(hop), .enh_wr(enh_wr), .direct(direct), .enh_mode_n(enh_mode_n),
    .par_word(par_word), .cfg_word(cfg_word), .enh_word(enh_word), .dout(dout));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic gap();
    repeat (4) @(negedge clk);
  endtask

  task automatic sbit(input logic b);
    @(negedge clk); sdata = b; gap();
    sclk = 1; gap();
    sclk = 0; gap();
  endtask

  task automatic shift_n(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) sbit(v[i]);
  endtask

  task automatic pulse_load();
    @(negedge clk); load_n = 1; gap();
    load_n = 0; gap();
  endtask

  task automatic pulse_hop();
    @(negedge clk); hop = 1; gap();
    hop = 0; gap();
  endtask

  logic [W-1:0] cur;
  logic [W-1:0] lf;
  logic [E-1:0] ev;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    gap();
    // R9 reset state
    chk("R9 cfg", cfg_word, 0);
    enh_mode_n = 0; gap();
    chk("R9 enh", enh_word, 0);
    chk("R9 dout", dout, 0);
    enh_mode_n = 1;
    pulse_hop();
    chk("R9 primary zero", cfg_word, 0);

    // R1 walking ones through every bit position
    for (int i = 0; i < W; i++) begin
      shift_n(32'(1) << i, W);
      pulse_load();
      chk($sformatf("R1 walk %0d", i), cfg_word, 32'(1) << i);
    end
    // R1 pseudo-random words
    lf = 20'h5A3C1;
    for (int k = 0; k < 4; k++) begin
      lf = {lf[W-2:0], lf[W-1] ^ lf[2]};
      lf = lf ^ 20'h9E37;
      shift_n(32'(lf), W);
      chk("R4 no change before strobe", cfg_word, cur_or(k, lf));
      pulse_load();
      chk("R1 word", cfg_word, lf);
      cur = lf;
    end

    // R2 shifting ignored while load_n high
    @(negedge clk); load_n = 1; gap();
    shift_n(32'hFFFFF, W);
    @(negedge clk); load_n = 0; gap();
    pulse_hop();
    chk("R2 primary unchanged", cfg_word, cur);

    // R3 enhancement routing, R7 and R8 gating
    for (int v = 0; v < 4; v++) begin
      ev = (v == 0) ? 8'hA5 : (v == 1) ? 8'h3C : (v == 2) ? 8'h81 : 8'h7E;
      @(negedge clk); enh_wr = 1; gap();
      shift_n(32'(ev), E);
      @(negedge clk); enh_wr = 0; gap();
      pulse_hop();
      chk("R3 primary untouched", cfg_word, cur);
      enh_mode_n = 1; gap();
      chk("R7 gated off", enh_word, 0);
      chk("R8 dout off", dout, 0);
      enh_mode_n = 0; gap();
      chk("R7 enh value", enh_word, ev);
      chk("R8 dout msb", dout, ev[E-1]);
      enh_mode_n = 1;
    end

    // R5 hop transfer
    shift_n(32'hC0FFE, W);
    chk("R4 hold before hop", cfg_word, cur);
    pulse_hop();
    chk("R5 hop transfer", cfg_word, 20'hC0FFE);
    cur = 20'hC0FFE;

    // R10 partial shifts
    for (int n = 1; n <= 7; n += 3) begin
      shift_n(32'h15 & ((32'(1) << n) - 1), n);
      pulse_hop();
      cur = W'((cur << n) | (20'h15 & ((20'(1) << n) - 1)));
      chk($sformatf("R10 partial %0d", n), cfg_word, cur);
    end

    // R6 direct mode
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); direct = 1; par_word = W'(32'h1234 * (i + 3)); #1;
      chk("R6 direct", cfg_word, W'(32'h1234 * (i + 3)));
    end
    @(negedge clk); direct = 0; #1;
    chk("R6 serial", cfg_word, cur);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  function automatic logic [W-1:0] cur_or(input int k, input logic [W-1:0] x);
    return (k == 0) ? W'(32'(1) << (W - 1)) : cur;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule